// File: doc/BRIEF.md
# Two-Channel Digital Potentiometer Serial Slave

This block is the serial front end of a two-channel, 8-bit programmable resistor. It oversamples the two-wire bus lines (SCL and SDA) with the system clock and cleans them up. It recognises START and STOP conditions. It accepts a 7-bit device address, two bits of which come from strap inputs, so that four devices can share one bus.

A write transfer carries a command byte that picks a channel and sets four control flags. Any number of setting bytes may follow, and all of them reuse that command. Each accepted setting byte produces a one-cycle write strobe to the register block that sits beside this front end. A command byte that is followed directly by STOP or by a repeated START produces one strobe that carries only the flags. A read transfer has no command byte. It returns the current setting of the channel chosen by the most recent command, and that choice survives a repeated START.

The block drives SDA through an open-drain pull enable. It never stretches SCL.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The first byte after START is the address, sent MSB first. It matches when its upper seven bits equal 01011 followed by strap_addr[1] and then strap_addr[0]. On a match the slave asserts sda_pull through the ninth SCL clock. The last bit selects the direction: 0 for write, 1 for read.
- R2: An address that does not match gets no acknowledge. The slave then neither pulls SDA nor strobes until the next START.
- R3: In a write, the slave acknowledges the byte that follows the address and treats it as the command. Its fields are: bit 7 is the channel, bit 6 is midscale, bit 5 is shutdown, bit 4 is aux_hi and bit 3 is aux_lo. Bits 2 to 0 are ignored. wr_flags presents these as {midscale, shutdown, aux_hi, aux_lo}, and sel_chan follows bit 7.
- R4: Each setting byte after the command is acknowledged. It produces one wr_stb pulse lasting one cycle, with wr_has_data=1, the byte on wr_data, and the latched channel and flags.
- R5: Further setting bytes in the same transfer each strobe again with the same channel and flags.
- R6: A command byte followed by STOP or by a repeated START, with no setting byte in between, produces exactly one strobe with wr_has_data=0 that carries its channel and flags.
- R7: In a read, the slave sends set_ch0 or set_ch1, MSB first, starting right after the address acknowledge. The value sent is the one for the channel last named by a command.
- R8: The channel choice persists across a repeated START, so a command-only write followed by a read returns the channel just named.
- R9: When the master acknowledges a read byte (SDA low on the ninth clock), the same setting is sent again. When the master does not acknowledge (NACK), SDA stays released until the next START.
- R10: A pulse on SDA lasting one system-clock cycle while SCL is high is not taken as START or STOP, and the byte in progress completes unharmed.
- R11: A START or STOP in the middle of a byte abandons that byte without a data strobe and returns the slave to address reception (START) or to idle (STOP).
- R12: After reset, sda_pull, wr_stb and sel_chan are 0. sda_pull changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_addr | input | 2 | Address strap levels; bit 1 is the upper address bit |
| set_ch0 | input | 8 | Current setting of channel 0, from the register block |
| set_ch1 | input | 8 | Current setting of channel 1, from the register block |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle write strobe to the register block |
| wr_chan | output | 1 | Channel carried by the strobe |
| wr_flags | output | 4 | {midscale, shutdown, aux_hi, aux_lo} carried by the strobe |
| wr_data | output | 8 | Setting byte carried by the strobe |
| wr_has_data | output | 1 | 1 when the strobe carries a setting, 0 when it carries flags only |
| sel_chan | output | 1 | Channel named by the most recent command |

## Verification
Two functions can fall in the same cycle: the abort that a START or STOP causes, and the flags-only strobe owed by a command that has no setting byte yet. The bench provokes this in two ways. It follows a command byte directly with a repeated START, and it cuts a setting byte off after three bits with a repeated START. In both cases it expects exactly one strobe with wr_has_data=0, no data strobe, and a fresh acknowledge of the following address. A checker property separately requires every flags-only strobe to come from a bus condition seen one cycle earlier.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_READ,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic chan;
    logic midscale;
    logic shutdown;
    logic aux_hi;
    logic aux_lo;
  } cmd_t;

  // Address match: prefix, then upper strap, then lower strap, then R/W.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [4:0] pfx,
                                    input logic [1:0] strap);
    return b[BYTE_W-1:1] == {pfx, strap};
  endfunction

  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.chan     = b[7];
    c.midscale = b[6];
    c.shutdown = b[5];
    c.aux_hi   = b[4];
    c.aux_lo   = b[3];
    return c;
  endfunction

  function automatic logic [3:0] cmd_flags(input cmd_t c);
    return {c.midscale, c.shutdown, c.aux_hi, c.aux_lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_setting(input logic ch,
                                                     input logic [BYTE_W-1:0] v0,
                                                     input logic [BYTE_W-1:0] v1);
    return ch ? v1 : v0;
  endfunction

endpackage

// File: rtl/dpot_line_filter.sv
`timescale 1ns/1ps
module dpot_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   hold;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain[0] <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], line_i};
      end
    end
  endgenerate

  // Output moves only after two equal consecutive synchronized samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= 1'b1;
      line_o <= 1'b1;
    end else begin
      hold <= chain[SYNC_STAGES-1];
      if (chain[SYNC_STAGES-1] == hold) line_o <= hold;
    end
  end
endmodule

// File: rtl/dpot_bus_events.sv
`timescale 1ns/1ps
module dpot_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/dpot_xfer_fsm.sv
`timescale 1ns/1ps
module dpot_xfer_fsm
  import dpot_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_f,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] set_ch0,
  input  logic [BYTE_W-1:0] set_ch1,
  output logic              pull_o,
  output logic              stb_o,
  output logic              stb_chan_o,
  output logic [3:0]        stb_flags_o,
  output logic [BYTE_W-1:0] stb_data_o,
  output logic              stb_has_o,
  output logic              sel_chan_o,
  output logic              skip_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              in_ack;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              pull_r;
  logic              nack_r;
  logic              pend;
  cmd_t              cmd;
  logic [BYTE_W-1:0] rd_val;
  logic              bus_cond;

  assign rd_val   = pick_setting(cmd.chan, set_ch0, set_ch1);
  assign bus_cond = start_ev | stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      in_ack      <= 1'b0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      pull_r      <= 1'b0;
      nack_r      <= 1'b1;
      pend        <= 1'b0;
      cmd         <= '0;
      stb_o       <= 1'b0;
      stb_chan_o  <= 1'b0;
      stb_flags_o <= '0;
      stb_data_o  <= '0;
      stb_has_o   <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (bus_cond) begin
        // Abort whatever is in flight; settle an owed flags-only update.
        if (pend) begin
          stb_o       <= 1'b1;
          stb_has_o   <= 1'b0;
          stb_chan_o  <= cmd.chan;
          stb_flags_o <= cmd_flags(cmd);
        end
        pend   <= 1'b0;
        phase  <= start_ev ? PH_ADDR : PH_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        pull_r <= 1'b0;
      end else if (phase == PH_IDLE || phase == PH_SKIP) begin
        // wait for the next bus condition
      end else if (scl_rise) begin
        if (in_ack) begin
          if (phase == PH_READ) nack_r <= sda_f;
        end else if (cnt != CNT_FULL) begin
          cnt <= cnt + CNT_W'(1);
          if (phase != PH_READ) rx_sr <= {rx_sr[BYTE_W-2:0], sda_f};
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          // end of the ninth clock
          in_ack <= 1'b0;
          cnt    <= '0;
          pull_r <= 1'b0;
          if (phase == PH_READ) begin
            if (nack_r) begin
              phase <= PH_SKIP;
            end else begin
              tx_sr  <= rd_val;
              pull_r <= ~rd_val[BYTE_W-1];
            end
          end
        end else if (cnt == CNT_FULL) begin
          in_ack <= 1'b1;
          case (phase)
            PH_ADDR: begin
              if (addr_hit(rx_sr, ADDR_PREFIX, strap)) begin
                pull_r <= 1'b1;
                if (rx_sr[0]) begin
                  phase  <= PH_READ;
                  nack_r <= 1'b0;
                end else begin
                  phase  <= PH_CMD;
                end
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_CMD: begin
              pull_r <= 1'b1;
              cmd    <= decode_cmd(rx_sr);
              pend   <= 1'b1;
              phase  <= PH_WDATA;
            end
            PH_WDATA: begin
              pull_r      <= 1'b1;
              pend        <= 1'b0;
              stb_o       <= 1'b1;
              stb_has_o   <= 1'b1;
              stb_data_o  <= rx_sr;
              stb_chan_o  <= cmd.chan;
              stb_flags_o <= cmd_flags(cmd);
            end
            PH_READ: begin
              pull_r <= 1'b0;
            end
            default: begin
              phase <= PH_SKIP;
            end
          endcase
        end else if (phase == PH_READ && cnt != '0) begin
          tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
          pull_r <= ~tx_sr[BYTE_W-2];
        end
      end
    end
  end

  assign pull_o     = pull_r;
  assign sel_chan_o = cmd.chan;
  assign skip_o     = (phase == PH_SKIP);
endmodule

// File: rtl/dpot_i2c_slave.sv
`timescale 1ns/1ps
module dpot_i2c_slave
  import dpot_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        strap_addr,
  input  logic [BYTE_W-1:0] set_ch0,
  input  logic [BYTE_W-1:0] set_ch1,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic              wr_chan,
  output logic [3:0]        wr_flags,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_has_data,
  output logic              sel_chan
);
  logic scl_filt, sda_filt;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic skip_st;

  dpot_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_scl_flt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_in), .line_o(scl_filt)
  );

  dpot_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_sda_flt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_in), .line_o(sda_filt)
  );

  dpot_bus_events u_events (
    .clk(clk), .rst_n(rst_n),
    .scl_f(scl_filt), .sda_f(sda_filt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  dpot_xfer_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_f(sda_filt), .strap(strap_addr),
    .set_ch0(set_ch0), .set_ch1(set_ch1),
    .pull_o(sda_pull), .stb_o(wr_stb),
    .stb_chan_o(wr_chan), .stb_flags_o(wr_flags),
    .stb_data_o(wr_data), .stb_has_o(wr_has_data),
    .sel_chan_o(sel_chan), .skip_o(skip_st)
  );
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
`timescale 1ns/1ps
module dpot_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic skip_st,
  input logic sda_pull,
  input logic wr_stb,
  input logic wr_has_data
);
  // SDA drive only moves during the low phase of the filtered clock
  assert_pull_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  // strobes are single-cycle pulses
  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // a flags-only strobe is always caused by a bus condition
  assert_flags_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_has_data) |-> $past(start_ev || stop_ev));

  // a silent (unaddressed or finished-read) slave neither drives nor strobes
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> (!sda_pull && !wr_stb));

  // a bus condition releases SDA
  assert_cond_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_pull);
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_filt),
  .start_ev(start_ev), .stop_ev(stop_ev), .skip_st(skip_st),
  .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_has_data(wr_has_data)
);

// File: tb/dpot_i2c_slave_bench.sv
`timescale 1ns/1ps
module dpot_i2c_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] V0 = 8'hC3;
  localparam logic [7:0] V1 = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_pull, wr_stb, wr_chan, wr_has_data, sel_chan;
  logic [3:0] wr_flags;
  logic [7:0] wr_data;
  logic bus_sda;

  int n_chk = 0, n_bad = 0;
  int stb_cnt = 0;
  logic [7:0] l_data;
  logic l_chan, l_has;
  logic [3:0] l_flags;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign bus_sda = sda_m & ~sda_pull;

  dpot_i2c_slave u_dpot_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus_sda),
    .strap_addr(strap), .set_ch0(V0), .set_ch1(V1),
    .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_chan(wr_chan),
    .wr_flags(wr_flags), .wr_data(wr_data), .wr_has_data(wr_has_data),
    .sel_chan(sel_chan)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt <= stb_cnt + 1;
      l_data  <= wr_data;
      l_chan  <= wr_chan;
      l_has   <= wr_has_data;
      l_flags <= wr_flags;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] st, input logic rw);
    return {5'b01011, st, rw};
  endfunction

  task automatic bit_io(input logic b, input bit glitch, output logic s);
    wclk(2); sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    s = bus_sda;
    if (glitch) begin sda_m = 1'b0; wclk(1); sda_m = b; end
    wclk(Q); scl_m = 1'b0;
  endtask

  task automatic byte_tx(input logic [7:0] v, input int gbit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], (i == gbit), s);
    bit_io(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic byte_rx(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, 1'b0, s); v[i] = s; end
    bit_io(~mack, 1'b0, s);
  endtask

  task automatic do_start();
    if (scl_m == 1'b0) begin
      wclk(2); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    end
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic do_stop();
    wclk(2); sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic t_reset();
    #1;
    chk("R12 pull after reset", sda_pull, 0);
    chk("R12 strobe after reset", wr_stb, 0);
    chk("R12 sel_chan after reset", sel_chan, 0);
  endtask

  task automatic t_single_write();
    logic a; int c0 = stb_cnt;
    strap = 2'b01;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a); chk("R1 address ack", a, 1);
    byte_tx(8'h35, -1, a); chk("R3 command ack", a, 1);
    chk("R3 sel_chan", sel_chan, 0);
    byte_tx(8'h5A, -1, a); chk("R4 data ack", a, 1);
    chk("R4 one strobe", stb_cnt - c0, 1);
    chk("R4 data", l_data, 8'h5A);
    chk("R4 has_data", l_has, 1);
    chk("R3 flags", l_flags, 4'b0110);
    chk("R3 chan", l_chan, 0);
    do_stop();
    chk("R6 no flags strobe after data", stb_cnt - c0, 1);
  endtask

  task automatic t_mismatch();
    logic a; int c0 = stb_cnt;
    strap = 2'b01;
    do_start();
    byte_tx(abyte(2'b10, 1'b0), -1, a); chk("R2 no address ack", a, 0);
    byte_tx(8'h80, -1, a); chk("R2 no ack later", a, 0);
    do_stop();
    chk("R2 no strobe", stb_cnt - c0, 0);
  endtask

  task automatic t_multi();
    logic a; int c0 = stb_cnt;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h33};
    strap = 2'b10;
    do_start();
    byte_tx(abyte(2'b10, 1'b0), -1, a); chk("R1 ack other strap", a, 1);
    byte_tx(8'hC8, -1, a); chk("R3 command ack", a, 1);
    chk("R3 sel_chan follows bit7", sel_chan, 1);
    for (int k = 0; k < 3; k++) begin
      byte_tx(vals[k], -1, a);
      chk("R5 data ack", a, 1);
      chk("R5 data", l_data, vals[k]);
      chk("R5 chan", l_chan, 1);
      chk("R5 flags", l_flags, 4'b1001);
      chk("R5 count", stb_cnt - c0, k + 1);
    end
    do_stop();
  endtask

  task automatic t_flags_only();
    logic a; logic [7:0] v; int c0;
    strap = 2'b01;
    c0 = stb_cnt;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a);
    byte_tx(8'h10, -1, a);
    do_stop(); wclk(2);
    chk("R6 stop strobe count", stb_cnt - c0, 1);
    chk("R6 stop has_data", l_has, 0);
    chk("R6 stop flags", l_flags, 4'b0010);
    chk("R6 stop chan", l_chan, 0);
    c0 = stb_cnt;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a);
    byte_tx(8'h88, -1, a);
    do_start();
    chk("R6 rstart strobe count", stb_cnt - c0, 1);
    chk("R6 rstart has_data", l_has, 0);
    chk("R6 rstart flags", l_flags, 4'b0001);
    chk("R6 rstart chan", l_chan, 1);
    byte_tx(abyte(2'b01, 1'b1), -1, a); chk("R1 read address ack", a, 1);
    chk("R8 sel_chan kept", sel_chan, 1);
    byte_rx(1'b0, v);
    chk("R7 R8 read channel 1", v, V1);
    do_stop();
  endtask

  task automatic t_read_repeat();
    logic a, s; logic [7:0] v;
    strap = 2'b01;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a);
    byte_tx(8'h00, -1, a);
    do_start();
    byte_tx(abyte(2'b01, 1'b1), -1, a);
    byte_rx(1'b1, v); chk("R7 read channel 0", v, V0);
    byte_rx(1'b0, v); chk("R9 resend after ack", v, V0);
    bit_io(1'b1, 1'b0, s); chk("R9 released after nack", s, 1);
    do_stop();
    chk("R9 pull idle", sda_pull, 0);
  endtask

  task automatic t_glitch();
    logic a; int c0;
    strap = 2'b01;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a);
    byte_tx(8'h80, -1, a);
    c0 = stb_cnt;
    byte_tx(8'hA5, 7, a); chk("R10 ack despite glitch", a, 1);
    chk("R10 strobe count", stb_cnt - c0, 1);
    chk("R10 data intact", l_data, 8'hA5);
    do_stop();
  endtask

  task automatic t_abort();
    logic a, s; int c0;
    strap = 2'b01;
    do_start();
    byte_tx(abyte(2'b01, 1'b0), -1, a);
    byte_tx(8'h00, -1, a);
    c0 = stb_cnt;
    bit_io(1'b1, 1'b0, s); bit_io(1'b0, 1'b0, s); bit_io(1'b1, 1'b0, s);
    do_start();
    chk("R11 single strobe on abort", stb_cnt - c0, 1);
    chk("R11 no data strobe", l_has, 0);
    byte_tx(abyte(2'b01, 1'b0), -1, a); chk("R11 address after abort", a, 1);
    do_stop();
  endtask

  initial begin
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset();
    t_single_write();
    t_mismatch();
    t_multi();
    t_flags_only();
    t_read_repeat();
    t_glitch();
    t_abort();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule